// File: doc/BRIEF.md
# Segmented Address Translation Front End

This block sits ahead of a paged translation unit and decides, for each 32-bit virtual address, which of three routes it takes. When translation is switched off in the global configuration word, the address goes through unchanged with full access rights. When translation is on, a kernel-mode access to a segment marked for direct mapping has its top nibble replaced by a per-segment physical base, again with full rights. Every other access, whether from user mode or to an unmarked segment, is flagged as needing a page lookup, and the downstream lookup unit takes it from there.

A segment is one sixteenth of the address space, named by address bits 31..28. Each segment's 4-bit base is held in one of two 32-bit base registers: segments 0..7 use the low register and segments 8..15 use the high one. Within a register the base sits at bit offset 4*(segment mod 8). A request is presented with a valid pulse. One cycle later the result appears with an output valid pulse, and the result fields keep their values until the next request.

Top module: `seg_xlate_top`

## Requirements
- R1: The outputs settle one clock after a cycle in which req_valid is high. rsp_valid is high for exactly that one cycle and is low in every cycle that does not follow an accepted request.
- R2: If bits 2 and 3 of glb_cfg are both zero, the result is phys_addr = virt_addr, full_perm = 1 and need_lookup = 0, whatever the mode and the segment bits.
- R3: The segment is virt_addr[31:28]. It is direct-mapped only when translation is enabled (glb_cfg[2] or glb_cfg[3] set), user_mode = 0, and mmu_cfg[segment] = 1.
- R4: For a direct-mapped segment, phys_addr[27:0] = virt_addr[27:0] and phys_addr[31:28] is the base nibble. For segments 0..7 the nibble is kbase_lo[4*s+3:4*s]. For segments 8..15 it is kbase_hi[4*(s-8)+3:4*(s-8)]. In this case full_perm = 1 and need_lookup = 0.
- R5: When translation is enabled and the access is not direct-mapped (user_mode = 1, or mmu_cfg[segment] = 0), need_lookup = 1, full_perm = 0, and phys_addr = virt_addr.
- R6: need_lookup and full_perm are never both 1.
- R7: phys_addr, full_perm and need_lookup hold their values while no request is accepted.
- R8: A synchronous active-high rst clears rsp_valid, need_lookup and full_perm, and sets phys_addr to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is presented this cycle |
| virt_addr | input | 32 | Virtual address |
| user_mode | input | 1 | 1 for a user-mode access |
| glb_cfg | input | 32 | Global configuration; bit 2 or bit 3 enables translation |
| mmu_cfg | input | 32 | Bits 15..0 mark segments that are direct-mapped |
| kbase_lo | input | 32 | Base nibbles for segments 0..7 |
| kbase_hi | input | 32 | Base nibbles for segments 8..15 |
| rsp_valid | output | 1 | Result is valid (one-cycle pulse) |
| phys_addr | output | 32 | Translated or passed-through address |
| full_perm | output | 1 | Full access rights granted |
| need_lookup | output | 1 | Paged translation is required |

## Verification
The bench steps through every segment with a single enable bit set in turn. A design that swapped the two base registers, or computed the nibble offset from the full segment number, would place the wrong nibble in the top of the address. The enable test drives each of bit 2 and bit 3 alone, and also drives other bits without them: a decoder that looked at the wrong bits would translate when it should pass through, or pass through when it should translate. User mode is driven with every mmu_cfg bit set, which shows up a design that lets user accesses bypass paging. Idle cycles after each response check that the valid pulse lasts one cycle and that the result fields hold their values.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int ADDR_W  = 32;
  localparam int SEG_W   = 4;
  localparam int NSEG    = 1 << SEG_W;
  localparam int HALF    = NSEG / 2;
  localparam int OFF_W   = ADDR_W - SEG_W;

  typedef enum logic [1:0] {
    ROUTE_PASS  = 2'd0,
    ROUTE_SEG   = 2'd1,
    ROUTE_PAGED = 2'd2
  } route_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic              perm;
    logic              lookup;
  } xlate_res_t;
endpackage

// File: rtl/seg_route_dec.sv
module seg_route_dec
  import seg_xlate_pkg::*;
#(
  parameter int EN_BIT_A = 2,
  parameter int EN_BIT_B = 3
) (
  input  logic [ADDR_W-1:0] virt_addr,
  input  logic              user_mode,
  input  logic [31:0]       glb_cfg,
  input  logic [31:0]       mmu_cfg,
  output route_e            route
);
  logic [SEG_W-1:0] seg;
  logic             xl_en;
  logic             seg_hit;

  assign seg     = virt_addr[ADDR_W-1 -: SEG_W];
  assign xl_en   = glb_cfg[EN_BIT_A] | glb_cfg[EN_BIT_B];
  assign seg_hit = mmu_cfg[seg] & ~user_mode;

  always_comb begin
    if (!xl_en)       route = ROUTE_PASS;
    else if (seg_hit) route = ROUTE_SEG;
    else              route = ROUTE_PAGED;
  end

  always_comb begin
    a_r5_user_never_seg: assert (!(user_mode && route == ROUTE_SEG));
  end
endmodule

// File: rtl/seg_base_sel.sv
module seg_base_sel
  import seg_xlate_pkg::*;
(
  input  logic [SEG_W-1:0] seg,
  input  logic [31:0]      kbase_lo,
  input  logic [31:0]      kbase_hi,
  output logic [SEG_W-1:0] base
);
  localparam int IDX_W = SEG_W - 1;
  logic [SEG_W-1:0] nib_lo [HALF];
  logic [SEG_W-1:0] nib_hi [HALF];
  logic [IDX_W-1:0] idx;

  genvar g;
  generate
    for (g = 0; g < HALF; g++) begin : g_nib
      assign nib_lo[g] = kbase_lo[g*SEG_W +: SEG_W];
      assign nib_hi[g] = kbase_hi[g*SEG_W +: SEG_W];
    end
  endgenerate

  assign idx  = seg[IDX_W-1:0];
  assign base = seg[SEG_W-1] ? nib_hi[idx] : nib_lo[idx];
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
  import seg_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] virt_addr,
  input  logic              user_mode,
  input  logic [31:0]       glb_cfg,
  input  logic [31:0]       mmu_cfg,
  input  logic [31:0]       kbase_lo,
  input  logic [31:0]       kbase_hi,
  output logic              rsp_valid,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              full_perm,
  output logic              need_lookup
);
  route_e           route;
  logic [SEG_W-1:0] base;
  xlate_res_t       nxt;

  seg_route_dec u_dec (
    .virt_addr(virt_addr), .user_mode(user_mode),
    .glb_cfg(glb_cfg), .mmu_cfg(mmu_cfg), .route(route)
  );

  seg_base_sel u_base (
    .seg(virt_addr[ADDR_W-1 -: SEG_W]),
    .kbase_lo(kbase_lo), .kbase_hi(kbase_hi), .base(base)
  );

  always_comb begin
    nxt.addr   = virt_addr;
    nxt.perm   = 1'b0;
    nxt.lookup = 1'b0;
    unique case (route)
      ROUTE_SEG: begin
        nxt.addr = {base, virt_addr[OFF_W-1:0]};
        nxt.perm = 1'b1;
      end
      ROUTE_PAGED: nxt.lookup = 1'b1;
      default:     nxt.perm = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      phys_addr   <= '0;
      full_perm   <= 1'b0;
      need_lookup <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        phys_addr   <= nxt.addr;
        full_perm   <= nxt.perm;
        need_lookup <= nxt.lookup;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
  a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(full_perm && need_lookup));
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> $stable(phys_addr) && $stable(need_lookup) && $stable(full_perm));
  a_r2_pass: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !glb_cfg[2] && !glb_cfg[3]) |=> (phys_addr == $past(virt_addr)) && full_perm);
  a_r4_offset_kept: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> phys_addr[OFF_W-1:0] == $past(virt_addr[OFF_W-1:0]));
endmodule

// File: tb/seg_xlate_top_tb.sv
module seg_xlate_top_tb;
  logic clk = 0, rst = 1, req_valid = 0, user_mode = 0;
  logic [31:0] virt_addr = 0, glb_cfg = 0, mmu_cfg = 0, kbase_lo = 0, kbase_hi = 0;
  logic rsp_valid, full_perm, need_lookup;
  logic [31:0] phys_addr;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  seg_xlate_top u_dut (.clk, .rst, .req_valid, .virt_addr, .user_mode, .glb_cfg,
    .mmu_cfg, .kbase_lo, .kbase_hi, .rsp_valid, .phys_addr, .full_perm, .need_lookup);

  task automatic chk(string req, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [33:0] model(logic [31:0] va, logic um, logic [31:0] g,
      logic [31:0] m, logic [31:0] lo, logic [31:0] hi);
    int s = va[31:28];
    logic [3:0] b;
    if (!(g[2] | g[3])) return {va, 2'b10};
    if (!um && m[s]) begin
      b = (s < 8) ? lo[4*s +: 4] : hi[4*(s-8) +: 4];
      return {b, va[27:0], 2'b10};
    end
    return {va, 2'b01};
  endfunction

  task automatic run(string req, logic [31:0] va, logic um, logic [31:0] g,
      logic [31:0] m, logic [31:0] lo, logic [31:0] hi);
    logic [33:0] exp, held;
    exp = model(va, um, g, m, lo, hi);
    @(negedge clk);
    req_valid = 1; virt_addr = va; user_mode = um; glb_cfg = g; mmu_cfg = m;
    kbase_lo = lo; kbase_hi = hi;
    @(negedge clk);
    req_valid = 0;
    chk("R1 valid", {33'b0, rsp_valid}, 34'd1);
    chk(req, {phys_addr, full_perm, need_lookup}, exp);
    chk("R6 exclusive", {33'b0, full_perm & need_lookup}, 34'd0);
    held = {phys_addr, full_perm, need_lookup};
    virt_addr = ~va; user_mode = ~um; glb_cfg = ~g;
    @(negedge clk);
    chk("R1 pulse", {33'b0, rsp_valid}, 34'd0);
    chk("R7 hold", {phys_addr, full_perm, need_lookup}, held);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R8 reset", {phys_addr, full_perm, need_lookup}, 34'd0);
    chk("R8 reset valid", {33'b0, rsp_valid}, 34'd0);
    rst = 0;
    // R2: disabled, various modes
    run("R2 pass", 32'hDEADBEEF, 1'b0, 32'hFFFF_FFF3, 32'hFFFF, 32'h1234_5678, 32'h9ABC_DEF0);
    run("R2 pass user", 32'h1234_5678, 1'b1, 32'h0, 32'hFFFF, 32'h0, 32'h0);
    // R3/R4: each segment direct-mapped, enable via bit 2 then bit 3
    for (int s = 0; s < 16; s++)
      run("R4 seg", {s[3:0], 28'hA5C3E17}, 1'b0, (s % 2) ? 32'h8 : 32'h4,
          32'h1 << s, 32'h7654_3210, 32'hFEDC_BA98);
    // R5: user mode with all segments marked
    for (int s = 0; s < 16; s += 5)
      run("R5 user", {s[3:0], 28'h0123456}, 1'b1, 32'h4, 32'hFFFF, 32'h7654_3210, 32'hFEDC_BA98);
    // R5/R3: kernel, segment bit clear
    run("R3 clear", 32'h7000_0040, 1'b0, 32'h8, 32'hFF7F, 32'h0, 32'h0);
    // random
    for (int i = 0; i < 300; i++)
      run("R3 rand", $urandom, 1'($urandom), $urandom, $urandom, $urandom, $urandom);
    // R8: reset mid-stream
    @(negedge clk); req_valid = 1; glb_cfg = 0;
    @(negedge clk); req_valid = 0; rst = 1;
    @(negedge clk); rst = 0;
    chk("R8 reset again", {phys_addr, full_perm, need_lookup}, 34'd0);
    chk("R8 reset valid again", {33'b0, rsp_valid}, 34'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule